// File: doc/BRIEF.md
# Integer ALU with Set-on-Condition Compare

This block is the combinational integer execute unit of a small load-store processor. It takes two operands and a five-bit operation code, and in the same cycle it returns one result word together with a zero flag and a signed-overflow flag. It has no clock and no state. The surrounding pipeline registers its outputs.

The operations are:
- signed and unsigned forms of add and subtract, where only the signed forms can raise overflow;
- bitwise AND, OR and XOR;
- three shifts: logical left, logical right and arithmetic right;
- an operation that places an immediate in the upper half of the word;
- six signed comparisons that return the word 1 or the word 0.

The design has no states or transitions. Operation selection is one `unique case` over an enumerated opcode type. An adder/subtractor, a barrel shifter and a comparator feed that selection.

Top module: `int_alu`

## Requirements
- R1: Opcodes 0 (signed add) and 2 (signed subtract) return a+b and a−b modulo 2^32. The overflow flag is 1 exactly when the true two's-complement result lies outside [−2^31, 2^31−1].
- R2: Opcodes 1 (unsigned add) and 3 (unsigned subtract) return the same words as opcodes 0 and 2, and the overflow flag stays 0.
- R3: Opcodes 4, 5 and 6 return a AND b, a OR b and a XOR b.
- R4: Opcodes 7 (shift left) and 8 (logical shift right) shift a by b[4:0] and fill with zeros. Bits b[31:5] have no effect on the result.
- R5: Opcode 9 shifts a right by b[4:0] and fills the vacated bits with copies of a[31].
- R6: Opcode 10 returns {b[15:0], 16'h0000}. Operand a has no effect.
- R7: Opcodes 11 to 16 compare a and b as signed numbers under the conditions less-than, greater-than, less-or-equal, greater-or-equal, equal and not-equal, in that opcode order. The result is 32'd1 when the condition holds and 32'd0 when it does not.
- R8: The zero flag is 1 exactly when the 32-bit result is all zeros.
- R9: Opcodes 17 to 31 are undefined. They return result 0 with overflow 0.
- R10: Overflow is 0 for every opcode other than 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; also supplies the shift amount and the immediate |
| op_sel | input | 5 | Operation code (see requirements) |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed add/subtract overflow |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, which gives a five-bit shift amount and a 16-bit immediate. At that width the directed cases reach every overflow boundary, including 0x7FFFFFFF+1, 0x80000000−1 and the negation of 0x80000000. They also reach shifts by 0 and 31, where unused upper bits of the second operand must be ignored. Random operands cover all 32 opcode values, including the undefined ones, and biased picks make the equal-operand compares occur often.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_SLL  = 5'd7,
        OP_SRL  = 5'd8,
        OP_SRA  = 5'd9,
        OP_LHI  = 5'd10,
        OP_SLT  = 5'd11,
        OP_SGT  = 5'd12,
        OP_SLE  = 5'd13,
        OP_SGE  = 5'd14,
        OP_SEQ  = 5'd15,
        OP_SNE  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             sgn_ovf
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff   = do_sub ? ~in_b : in_b;
        wide    = {1'b0, in_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
        sum     = wide[WIDTH-1:0];
        sgn_ovf = (in_a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != in_a[WIDTH-1]);
    end

    // Independent check: sign-extended result whose top two bits disagree means out of range
    logic [WIDTH:0] ext_res;
    always_comb begin
        ext_res = do_sub ? ({in_a[WIDTH-1], in_a} - {in_b[WIDTH-1], in_b})
                         : ({in_a[WIDTH-1], in_a} + {in_b[WIDTH-1], in_b});
        p_ovf_range_r1: assert (sgn_ovf == (ext_res[WIDTH] != ext_res[WIDTH-1]))
            else $error("overflow flag disagrees with extended result");
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   din,
    input  logic [SHAMT_W-1:0] amt,
    input  shift_kind_e        kind,
    output logic [WIDTH-1:0]   dout
);
    logic [WIDTH-1:0] stage [SHAMT_W+1];
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic             fill;

    // Left shifts reuse the right shifter by reversing bit order
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev
            assign rev_in[i]  = din[WIDTH-1-i];
            assign rev_out[i] = stage[SHAMT_W][WIDTH-1-i];
        end
    endgenerate

    assign fill     = (kind == SH_ARITH) && din[WIDTH-1];
    assign stage[0] = (kind == SH_LEFT) ? rev_in : din;

    generate
        for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]} : stage[k];
        end
    endgenerate

    assign dout = (kind == SH_LEFT) ? rev_out : stage[SHAMT_W];

    always_comb begin
        if (amt == '0)
            p_shift_zero_r4: assert (dout == din) else $error("zero shift altered data");
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             lt,
    output logic             eq
);
    assign lt = $signed(in_a) < $signed(in_b);
    assign eq = (in_a == in_b);

    always_comb begin
        p_lt_eq_excl_r7: assert (!(lt && eq)) else $error("less-than and equal both set");
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [4:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);
    localparam int SHAMT_W = $clog2(WIDTH);
    localparam int IMM_W   = WIDTH / 2;

    alu_op_e          op;
    logic             do_sub;
    logic [WIDTH-1:0] as_sum;
    logic             as_ovf;
    shift_kind_e      sh_kind;
    logic [WIDTH-1:0] sh_out;
    logic             c_lt;
    logic             c_eq;

    assign op     = alu_op_e'(op_sel);
    assign do_sub = (op == OP_SUB) || (op == OP_SUBU);

    always_comb begin
        unique case (op)
            OP_SLL:  sh_kind = SH_LEFT;
            OP_SRA:  sh_kind = SH_ARITH;
            default: sh_kind = SH_RIGHT;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .in_a    (opnd_a),
        .in_b    (opnd_b),
        .do_sub  (do_sub),
        .sum     (as_sum),
        .sgn_ovf (as_ovf)
    );

    alu_shifter #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
        .din  (opnd_a),
        .amt  (opnd_b[SHAMT_W-1:0]),
        .kind (sh_kind),
        .dout (sh_out)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .in_a (opnd_a),
        .in_b (opnd_b),
        .lt   (c_lt),
        .eq   (c_eq)
    );

    logic cond;
    logic is_set;

    always_comb begin
        result   = '0;
        ovf_flag = 1'b0;
        cond     = 1'b0;
        is_set   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result   = as_sum;
                ovf_flag = as_ovf;
            end
            OP_ADDU, OP_SUBU: result = as_sum;
            OP_AND: result = opnd_a & opnd_b;
            OP_OR:  result = opnd_a | opnd_b;
            OP_XOR: result = opnd_a ^ opnd_b;
            OP_SLL, OP_SRL, OP_SRA: result = sh_out;
            OP_LHI: result = {opnd_b[IMM_W-1:0], {(WIDTH-IMM_W){1'b0}}};
            OP_SLT, OP_SGT, OP_SLE, OP_SGE, OP_SEQ, OP_SNE: begin
                is_set = 1'b1;
                unique case (op)
                    OP_SLT:  cond = c_lt;
                    OP_SGT:  cond = !c_lt && !c_eq;
                    OP_SLE:  cond = c_lt || c_eq;
                    OP_SGE:  cond = !c_lt;
                    OP_SEQ:  cond = c_eq;
                    default: cond = !c_eq;
                endcase
                result = {{(WIDTH-1){1'b0}}, cond};
            end
            default: result = '0;
        endcase
    end

    assign zero_flag = (result == '0);

    always_comb begin
        if (is_set)
            p_set_word_r7: assert (result[WIDTH-1:1] == '0) else $error("set result wider than one bit");
        if (op == OP_LHI)
            p_lhi_low_r6: assert (result[WIDTH-IMM_W-1:0] == '0) else $error("immediate low half not clear");
    end
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [4:0]  op;
    logic [31:0] res;
    logic        zf, of;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    int_alu u_dut (
        .opnd_a    (a),
        .opnd_b    (b),
        .op_sel    (op),
        .result    (res),
        .zero_flag (zf),
        .ovf_flag  (of)
    );

    function automatic string tag_of(input logic [4:0] o);
        if (o <= 5'd3 && !o[0]) return "R1";
        if (o <= 5'd3)          return "R2";
        if (o <= 5'd6)          return "R3";
        if (o <= 5'd8)          return "R4";
        if (o == 5'd9)          return "R5";
        if (o == 5'd10)         return "R6";
        if (o <= 5'd16)         return "R7";
        return "R9";
    endfunction

    function automatic void model(input logic [31:0] x, input logic [31:0] y, input logic [4:0] o,
                                  output logic [31:0] r, output logic v);
        longint sx, sy, t;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        r = 32'd0;
        v = 1'b0;
        case (o)
            5'd0, 5'd1: begin
                r = x + y;
                t = sx + sy;
                v = (o == 5'd0) && (t > 64'sd2147483647 || t < -64'sd2147483648);
            end
            5'd2, 5'd3: begin
                r = x - y;
                t = sx - sy;
                v = (o == 5'd2) && (t > 64'sd2147483647 || t < -64'sd2147483648);
            end
            5'd4:  r = x & y;
            5'd5:  r = x | y;
            5'd6:  r = x ^ y;
            5'd7:  r = x << y[4:0];
            5'd8:  r = x >> y[4:0];
            5'd9:  r = 32'($signed(x) >>> y[4:0]);
            5'd10: r = {y[15:0], 16'h0};
            5'd11: r = {31'd0, sx <  sy};
            5'd12: r = {31'd0, sx >  sy};
            5'd13: r = {31'd0, sx <= sy};
            5'd14: r = {31'd0, sx >= sy};
            5'd15: r = {31'd0, sx == sy};
            5'd16: r = {31'd0, sx != sy};
            default: r = 32'd0;
        endcase
    endfunction

    task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [4:0] o);
        logic [31:0] er;
        logic        ev;
        @(posedge clk);
        #1;
        a = x; b = y; op = o;
        model(x, y, o, er, ev);
        @(negedge clk);
        n_checks++;
        if (res !== er) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%h b=%h result=%h expected=%h", tag_of(o), o, x, y, res, er);
        end
        n_checks++;
        if (zf !== (er == 32'd0)) begin
            n_errors++;
            $display("FAIL R8 op=%0d zero=%b expected=%b", o, zf, (er == 32'd0));
        end
        n_checks++;
        if (of !== ev) begin
            n_errors++;
            $display("FAIL %s op=%0d a=%h b=%h ovf=%b expected=%b",
                     (o == 5'd0 || o == 5'd2) ? "R1" : "R10", o, x, y, of, ev);
        end
    endtask

    initial begin
        a = 32'd0; b = 32'd0; op = 5'd0;
        void'($urandom(32'h5EED_0A1B));
        // initial state: zero operands, add -> zero result (R8)
        run(32'd0, 32'd0, 5'd0);
        // R1 overflow boundaries
        run(32'h7FFF_FFFF, 32'd1, 5'd0);
        run(32'h8000_0000, 32'd1, 5'd2);
        run(32'd0, 32'h8000_0000, 5'd2);
        run(32'h8000_0000, 32'h8000_0000, 5'd0);
        run(32'hFFFF_FFFF, 32'd1, 5'd0);
        // R2 same words, never overflow
        run(32'h7FFF_FFFF, 32'd1, 5'd1);
        run(32'h8000_0000, 32'd1, 5'd3);
        // R3
        run(32'hF0F0_A5A5, 32'h0FF0_FFFF, 5'd4);
        run(32'hF0F0_A5A5, 32'h0FF0_0000, 5'd5);
        run(32'hFFFF_0000, 32'hFFFF_0000, 5'd6);
        // R4 / R5 with upper shift bits set
        run(32'h8000_0001, 32'hFFFF_FFE0, 5'd7);
        run(32'h8000_0001, 32'h0000_001F, 5'd7);
        run(32'h8000_0001, 32'hABCD_EF3F, 5'd8);
        run(32'h8000_0000, 32'd31, 5'd9);
        run(32'h4000_0000, 32'd30, 5'd9);
        run(32'h8765_4321, 32'hFFFF_FFE4, 5'd9);
        // R6 a ignored
        run(32'hDEAD_BEEF, 32'h1234_ABCD, 5'd10);
        run(32'd0, 32'hFFFF_0000, 5'd10);
        // R7 signed compares incl. equal and sign-crossing
        for (int o = 11; o <= 16; o++) begin
            run(32'hFFFF_FFFF, 32'd1, 5'(o));
            run(32'd1, 32'hFFFF_FFFF, 5'(o));
            run(32'h1234_5678, 32'h1234_5678, 5'(o));
            run(32'h8000_0000, 32'h7FFF_FFFF, 5'(o));
        end
        // R9 undefined codes
        for (int o = 17; o < 32; o++) run(32'h7FFF_FFFF, 32'h0000_0001, 5'(o));
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = ($urandom_range(0, 7) == 0) ? x : $urandom();
            if ($urandom_range(0, 5) == 0) x = {x[31], 31'h7FFF_FFFF ^ {31{x[0]}}};
            run(x, y, 5'($urandom_range(0, 31)));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired, done=%b expected=1", done);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule